// File: doc/BRIEF.md
# Dual-Domain I/Q Capture Packer

This block records a fixed-length run of paired I/Q samples arriving from two unrelated clock domains. One domain supplies transmit samples and the other supplies feedback (loop-back receive) samples. Each source presents a 32-bit word per sample pair, qualified by a valid strobe. The block carries each stream into a common capture clock through its own small gray-pointer dual-clock FIFO. Once both FIFOs hold a word, it pops one word from each and joins them into a 64-bit record with four signed 16-bit slots. The slots sit in this order from the least significant end: transmit I, transmit Q, feedback I, feedback Q.

Pairs of records are packed into 128-bit words, with the earlier record in the low half, and buffered in a single-clock FIFO. Each 128-bit word is then split across two independent 16-bit output lanes, one per external memory. The transmit lane carries only transmit slots and the feedback lane carries only feedback slots. Every lane emits its samples in strictly increasing sample order, I before Q, so even and odd samples cannot trade places.

A start pulse arms a run of `RUN_LEN` records. When the last record has been taken, `done` rises and the inputs are ignored until the next start. A write into a full crossing FIFO is never lost silently: it raises a sticky error flag.

Top module: `iq_dual_capture`

## Requirements
- R1: Each source word carries I in bits [15:0] and Q in bits [31:16]. Each lane emits the I slot of a sample pair before its Q slot.
- R2: The transmit lane emits only transmit slots and the feedback lane emits only feedback slots. Each lane emits them in strictly increasing sample order (I0, Q0, I1, Q1, …), with no displacement between even and odd samples.
- R3: A record is formed only when both crossing FIFOs hold a word. The n-th transmit word is always paired with the n-th feedback word, so both lanes emit the same number of samples over a run.
- R4: After reset, both lane valids, `done` and `ovf_err` are 0. Source words presented before the first start pulse produce no lane output.
- R5: A run takes exactly `RUN_LEN` records and then asserts `done`, giving exactly 2·`RUN_LEN` samples on each lane.
- R6: While `done` is 1, source words are ignored and produce no lane output, and `done` stays 1. A start pulse clears `done` on the next cycle and re-arms a new run.
- R7: A source word written while its crossing FIFO is full sets `ovf_err`, which then stays 1 until reset.
- R8: A lane whose valid is 1 while its ready is 0 keeps valid at 1 and its data unchanged in the next cycle.
- R9: A start pulse that arrives while a run is in progress is ignored. The run still ends after exactly `RUN_LEN` records, with the lane order intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture clock for record forming and both lanes |
| cap_rst_n | input | 1 | Active-low reset, capture domain |
| start | input | 1 | One-cycle pulse that arms a run (capture domain) |
| tx_clk | input | 1 | Transmit source clock |
| tx_rst_n | input | 1 | Active-low reset, transmit domain |
| tx_valid | input | 1 | Transmit word strobe |
| tx_data | input | 32 | Transmit word, Q in [31:16], I in [15:0] |
| fb_clk | input | 1 | Feedback source clock |
| fb_rst_n | input | 1 | Active-low reset, feedback domain |
| fb_valid | input | 1 | Feedback word strobe |
| fb_data | input | 32 | Feedback word, Q in [31:16], I in [15:0] |
| tx_lane_valid | output | 1 | Transmit lane sample valid |
| tx_lane_ready | input | 1 | Transmit lane sink ready |
| tx_lane_data | output | 16 | Transmit lane sample |
| fb_lane_valid | output | 1 | Feedback lane sample valid |
| fb_lane_ready | input | 1 | Feedback lane sink ready |
| fb_lane_data | output | 16 | Feedback lane sample |
| done | output | 1 | Run complete; inputs ignored until next start |
| ovf_err | output | 1 | Sticky crossing-FIFO overflow flag |

## Verification
The bench shortens `RUN_LEN` to 24 records and keeps eight-entry crossing FIFOs and a four-word pack FIFO. With these values several complete runs, a restart and a deliberate overflow fit in a few thousand cycles. Because the run length is this short, the end-of-run stop, the ignore-after-done window and the re-arm can be reached directly. Because the buffers are this shallow, holding both lanes not-ready fills every stage, and the overflow path is reached within about twenty source words. The two source clocks and the capture clock are mutually unrelated, and ready is randomised per lane. This exercises the gray-pointer crossings and the independent lane stalls, while the bench tracks the expected index sequence on each lane.

// File: rtl/iqcap_pkg.sv
package iqcap_pkg;
   localparam int SLOT_W = 16;
   localparam int PAIR_W = 2 * SLOT_W;
   localparam int REC_W  = 4 * SLOT_W;
   localparam int PACK_W = 2 * REC_W;

   typedef logic [SLOT_W-1:0] slot_t;

   // least significant slot first: tx I, tx Q, fb I, fb Q
   typedef struct packed {
      slot_t fb_q;
      slot_t fb_i;
      slot_t tx_q;
      slot_t tx_i;
   } rec_t;
endpackage

// File: rtl/iqcap_sync.sv
module iqcap_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg1 <= '0;
         q    <= '0;
      end else begin
         stg1 <= d;
         q    <= stg1;
      end
   end
endmodule

// File: rtl/iqcap_async_fifo.sv
module iqcap_async_fifo #(
   parameter int W  = 32,
   parameter int AW = 3
) (
   input  logic         wclk,
   input  logic         wrst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         wr_ovf,
   input  logic         rclk,
   input  logic         rrst_n,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         rd_empty
);
   localparam int DEPTH = 1 << AW;

   if (AW < 2) begin : g_bad_aw
      $error("iqcap_async_fifo: AW must be at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wbin, wgray, rbin, rgray;
   logic [AW:0]  rgray_w, wgray_r;
   logic [AW:0]  wbin_nx, rbin_nx;
   logic         full;

   assign wbin_nx = wbin + 1'b1;
   assign rbin_nx = rbin + 1'b1;

   iqcap_sync #(.W(AW+1)) u_rsync (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
   iqcap_sync #(.W(AW+1)) u_wsync (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

   assign full = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});

   always_ff @(posedge wclk) begin
      if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         wr_ovf <= 1'b0;
      end else if (wr_en) begin
         if (full) begin
            wr_ovf <= 1'b1;
         end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
         end
      end
   end

   assign rd_empty = (rgray == wgray_r);
   assign rd_data  = mem[rbin[AW-1:0]];

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_en && !rd_empty) begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
   end
endmodule

// File: rtl/iqcap_pack_fifo.sv
module iqcap_pack_fifo #(
   parameter int W  = 128,
   parameter int AW = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1) begin : g_bad_aw
      $error("iqcap_pack_fifo: AW must be at least 1");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign dout  = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wp[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/iqcap_lane_ser.sv
module iqcap_lane_ser
   import iqcap_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [2*PAIR_W-1:0] lane_word,
   output logic              can_load,
   output logic              valid,
   input  logic              ready,
   output slot_t             data
);
   logic [2*PAIR_W-1:0] hold;
   logic [1:0]          idx;
   logic                busy;
   logic                fire;

   assign fire     = busy && ready;
   assign can_load = !busy || (fire && idx == 2'd3);
   assign valid    = busy;

   always_comb begin
      case (idx)
         2'd0:    data = hold[0*SLOT_W +: SLOT_W];
         2'd1:    data = hold[1*SLOT_W +: SLOT_W];
         2'd2:    data = hold[2*SLOT_W +: SLOT_W];
         default: data = hold[3*SLOT_W +: SLOT_W];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= '0;
         idx  <= '0;
         busy <= 1'b0;
      end else if (load) begin
         hold <= lane_word;
         idx  <= '0;
         busy <= 1'b1;
      end else if (fire) begin
         idx <= idx + 1'b1;
         if (idx == 2'd3) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/iq_dual_capture.sv
module iq_dual_capture
   import iqcap_pkg::*;
#(
   parameter int RUN_LEN  = 2457600,
   parameter int XFIFO_AW = 3,
   parameter int PACK_AW  = 2
) (
   input  logic        cap_clk,
   input  logic        cap_rst_n,
   input  logic        start,
   input  logic        tx_clk,
   input  logic        tx_rst_n,
   input  logic        tx_valid,
   input  logic [31:0] tx_data,
   input  logic        fb_clk,
   input  logic        fb_rst_n,
   input  logic        fb_valid,
   input  logic [31:0] fb_data,
   output logic        tx_lane_valid,
   input  logic        tx_lane_ready,
   output logic [15:0] tx_lane_data,
   output logic        fb_lane_valid,
   input  logic        fb_lane_ready,
   output logic [15:0] fb_lane_data,
   output logic        done,
   output logic        ovf_err
);
   localparam int CW = $clog2(RUN_LEN + 1);

   if (RUN_LEN < 2 || (RUN_LEN % 2) != 0) begin : g_bad_run
      $error("iq_dual_capture: RUN_LEN must be even and at least 2");
   end
   if (PAIR_W != 32) begin : g_bad_pair
      $error("iq_dual_capture: source words must be 32 bits");
   end

   // ---------------- arming, crossed into each source domain
   logic armed;
   logic tx_arm, fb_arm;

   iqcap_sync #(.W(1)) u_arm_tx (.clk(tx_clk), .rst_n(tx_rst_n), .d(armed), .q(tx_arm));
   iqcap_sync #(.W(1)) u_arm_fb (.clk(fb_clk), .rst_n(fb_rst_n), .d(armed), .q(fb_arm));

   // ---------------- crossing FIFOs
   logic [PAIR_W-1:0] tx_rd, fb_rd;
   logic              tx_empty, fb_empty;
   logic              tx_pop, fb_pop;
   logic              tx_ovf, fb_ovf, tx_ovf_c, fb_ovf_c;

   iqcap_async_fifo #(.W(PAIR_W), .AW(XFIFO_AW)) u_tx_xfifo (
      .wclk(tx_clk), .wrst_n(tx_rst_n), .wr_en(tx_valid && tx_arm), .wr_data(tx_data),
      .wr_ovf(tx_ovf),
      .rclk(cap_clk), .rrst_n(cap_rst_n), .rd_en(tx_pop), .rd_data(tx_rd), .rd_empty(tx_empty));

   iqcap_async_fifo #(.W(PAIR_W), .AW(XFIFO_AW)) u_fb_xfifo (
      .wclk(fb_clk), .wrst_n(fb_rst_n), .wr_en(fb_valid && fb_arm), .wr_data(fb_data),
      .wr_ovf(fb_ovf),
      .rclk(cap_clk), .rrst_n(cap_rst_n), .rd_en(fb_pop), .rd_data(fb_rd), .rd_empty(fb_empty));

   iqcap_sync #(.W(1)) u_ovf_tx (.clk(cap_clk), .rst_n(cap_rst_n), .d(tx_ovf), .q(tx_ovf_c));
   iqcap_sync #(.W(1)) u_ovf_fb (.clk(cap_clk), .rst_n(cap_rst_n), .d(fb_ovf), .q(fb_ovf_c));

   assign ovf_err = tx_ovf_c || fb_ovf_c;

   // ---------------- record forming and run control
   logic          pk_full, pk_empty, pk_push, pk_pop;
   logic [PACK_W-1:0] pk_dout;
   logic          rec_take;
   logic          half;
   rec_t          cur_rec, low_rec;
   logic [CW-1:0] rec_cnt;

   assign rec_take = armed && !tx_empty && !fb_empty && !pk_full;
   // while disarmed, anything left in the crossings is flushed
   assign tx_pop   = rec_take || (!armed && !tx_empty);
   assign fb_pop   = rec_take || (!armed && !fb_empty);

   assign cur_rec = '{fb_q: fb_rd[PAIR_W-1:SLOT_W], fb_i: fb_rd[SLOT_W-1:0],
                      tx_q: tx_rd[PAIR_W-1:SLOT_W], tx_i: tx_rd[SLOT_W-1:0]};

   assign pk_push = rec_take && half;

   always_ff @(posedge cap_clk or negedge cap_rst_n) begin
      if (!cap_rst_n) begin
         armed   <= 1'b0;
         done    <= 1'b0;
         half    <= 1'b0;
         rec_cnt <= '0;
         low_rec <= '0;
      end else if (!armed) begin
         if (start) begin
            armed   <= 1'b1;
            done    <= 1'b0;
            half    <= 1'b0;
            rec_cnt <= '0;
         end
      end else if (rec_take) begin
         half <= !half;
         if (!half) low_rec <= cur_rec;
         if (rec_cnt == CW'(RUN_LEN - 1)) begin
            armed <= 1'b0;
            done  <= 1'b1;
         end
         rec_cnt <= rec_cnt + 1'b1;
      end
   end

   iqcap_pack_fifo #(.W(PACK_W), .AW(PACK_AW)) u_pack (
      .clk(cap_clk), .rst_n(cap_rst_n),
      .push(pk_push), .din({cur_rec, low_rec}), .full(pk_full),
      .pop(pk_pop), .dout(pk_dout), .empty(pk_empty));

   // ---------------- lane split: lane 0 = tx slots, lane 1 = fb slots
   logic [1:0]  ln_can, ln_valid, ln_ready;
   slot_t       ln_data [2];

   assign ln_ready = {fb_lane_ready, tx_lane_ready};
   assign pk_pop   = !pk_empty && (&ln_can);

   for (genvar L = 0; L < 2; L++) begin : g_lane
      logic [2*PAIR_W-1:0] lw;
      assign lw = {pk_dout[REC_W + L*PAIR_W +: PAIR_W], pk_dout[L*PAIR_W +: PAIR_W]};

      iqcap_lane_ser u_ser (
         .clk(cap_clk), .rst_n(cap_rst_n), .load(pk_pop), .lane_word(lw),
         .can_load(ln_can[L]), .valid(ln_valid[L]), .ready(ln_ready[L]), .data(ln_data[L]));
   end

   assign tx_lane_valid = ln_valid[0];
   assign tx_lane_data  = ln_data[0];
   assign fb_lane_valid = ln_valid[1];
   assign fb_lane_data  = ln_data[1];
endmodule

// File: rtl/iqcap_checker.sv
module iqcap_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        done,
   input logic        ovf_err,
   input logic        rec_take,
   input logic        txl_valid,
   input logic        txl_ready,
   input logic [15:0] txl_data,
   input logic        fbl_valid,
   input logic        fbl_ready,
   input logic [15:0] fbl_data
);
   // R8: stalled transmit lane holds
   p_hold_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      txl_valid && !txl_ready |=> txl_valid && $stable(txl_data));

   // R8: stalled feedback lane holds
   p_hold_fb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fbl_valid && !fbl_ready |=> fbl_valid && $stable(fbl_data));

   // R6: done persists until a start pulse
   p_done_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   // R6: start clears done
   p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done && start |=> !done);

   // R6: no record is taken while done
   p_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rec_take);

   // R7: overflow flag is sticky
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);
endmodule

bind iq_dual_capture iqcap_checker u_chk (
   .clk(cap_clk), .rst_n(cap_rst_n), .start(start), .done(done), .ovf_err(ovf_err),
   .rec_take(rec_take),
   .txl_valid(tx_lane_valid), .txl_ready(tx_lane_ready), .txl_data(tx_lane_data),
   .fbl_valid(fb_lane_valid), .fbl_ready(fb_lane_ready), .fbl_data(fb_lane_data));

// File: tb/sim_iq_dual_capture.sv
`timescale 1ns/1ps
module sim_iq_dual_capture;
   localparam int RUN = 24;

   logic cap_clk = 0, tx_clk = 0, fb_clk = 0;
   logic cap_rst_n = 0, tx_rst_n = 0, fb_rst_n = 0;
   logic start = 0;
   logic tx_valid = 0, fb_valid = 0;
   logic [31:0] tx_data = 0, fb_data = 0;
   logic tx_lane_valid, fb_lane_valid, done, ovf_err;
   logic tx_lane_ready = 0, fb_lane_ready = 0;
   logic [15:0] tx_lane_data, fb_lane_data;

   always #10   cap_clk = ~cap_clk;
   always #8.5  tx_clk  = ~tx_clk;
   always #11.5 fb_clk  = ~fb_clk;

   iq_dual_capture #(.RUN_LEN(RUN), .XFIFO_AW(3), .PACK_AW(2)) u0 (
      .cap_clk(cap_clk), .cap_rst_n(cap_rst_n), .start(start),
      .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
      .fb_clk(fb_clk), .fb_rst_n(fb_rst_n), .fb_valid(fb_valid), .fb_data(fb_data),
      .tx_lane_valid(tx_lane_valid), .tx_lane_ready(tx_lane_ready), .tx_lane_data(tx_lane_data),
      .fb_lane_valid(fb_lane_valid), .fb_lane_ready(fb_lane_ready), .fb_lane_data(fb_lane_data),
      .done(done), .ovf_err(ovf_err));

   int checks = 0, fails = 0;
   int tx_sent = 0, fb_sent = 0;
   int tx_cnt = 0, fb_cnt = 0;
   bit tx_ren = 0, fb_ren = 0;
   bit mon_on = 0;

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_tx(int s); return 16'(s); endfunction
   function automatic logic [15:0] exp_fb(int s); return 16'(32'h4000 + s); endfunction

   // sources: word n carries I = 2n, Q = 2n+1 (fb offset 0x4000); paced to stay within 2 words
   task automatic send_tx(int n, int gmax);
      for (int k = 0; k < n; k++) begin
         while (k > fb_sent + 2) @(negedge tx_clk);
         repeat ($urandom_range(gmax, 0)) @(negedge tx_clk);
         tx_valid = 1;
         tx_data  = {exp_tx(2*k+1), exp_tx(2*k)};
         @(negedge tx_clk);
         tx_valid = 0;
         tx_sent++;
      end
   endtask

   task automatic send_fb(int n, int gmax);
      for (int k = 0; k < n; k++) begin
         while (k > tx_sent + 2) @(negedge fb_clk);
         repeat ($urandom_range(gmax, 0)) @(negedge fb_clk);
         fb_valid = 1;
         fb_data  = {exp_fb(2*k+1), exp_fb(2*k)};
         @(negedge fb_clk);
         fb_valid = 0;
         fb_sent++;
      end
   endtask

   task automatic send_both(int n, int gmax);
      tx_sent = 0; fb_sent = 0;
      fork
         send_tx(n, gmax);
         send_fb(n, gmax);
      join
   endtask

   task automatic pulse_start;
      @(negedge cap_clk) start = 1;
      @(negedge cap_clk) start = 0;
   endtask

   // lane monitors: R1, R2, R8
   initial begin
      bit stall = 0;
      logic [15:0] held = 0;
      forever begin
         @(negedge cap_clk);
         tx_lane_ready = tx_ren && ($urandom_range(3, 0) != 0);
         #1;
         if (mon_on) begin
            if (stall) check(tx_lane_valid && tx_lane_data == held, "R8 tx hold", int'(tx_lane_data), int'(held));
            if (tx_lane_valid && tx_lane_ready) begin
               check(tx_lane_data == exp_tx(tx_cnt), "R1 R2 tx lane order", int'(tx_lane_data), int'(exp_tx(tx_cnt)));
               tx_cnt++;
            end
            stall = tx_lane_valid && !tx_lane_ready;
            held  = tx_lane_data;
         end
      end
   end

   initial begin
      bit stall = 0;
      logic [15:0] held = 0;
      forever begin
         @(negedge cap_clk);
         fb_lane_ready = fb_ren && ($urandom_range(3, 0) != 0);
         #1;
         if (mon_on) begin
            if (stall) check(fb_lane_valid && fb_lane_data == held, "R8 fb hold", int'(fb_lane_data), int'(held));
            if (fb_lane_valid && fb_lane_ready) begin
               check(fb_lane_data == exp_fb(fb_cnt), "R1 R2 fb lane order", int'(fb_lane_data), int'(exp_fb(fb_cnt)));
               fb_cnt++;
            end
            stall = fb_lane_valid && !fb_lane_ready;
            held  = fb_lane_data;
         end
      end
   end

   task automatic wait_drain(int n);
      for (int i = 0; i < 6000; i++) begin
         if (tx_cnt >= n && fb_cnt >= n && !tx_lane_valid && !fb_lane_valid) break;
         @(negedge cap_clk);
      end
      repeat (20) @(negedge cap_clk);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #3_000_000;
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge cap_clk);
      cap_rst_n = 1; tx_rst_n = 1; fb_rst_n = 1;
      @(negedge cap_clk); #2;
      // R4 reset state
      check(!tx_lane_valid && !fb_lane_valid, "R4 lanes idle", int'(tx_lane_valid), 0);
      check(!done, "R4 done low", int'(done), 0);
      check(!ovf_err, "R4 ovf low", int'(ovf_err), 0);

      mon_on = 1; tx_ren = 1; fb_ren = 1;
      // R4 words before any start are ignored
      send_both(3, 2);
      repeat (60) @(negedge cap_clk);
      check(tx_cnt == 0 && fb_cnt == 0, "R4 pre-start ignored", tx_cnt + fb_cnt, 0);

      // run 1 with a stray start in the middle (R9)
      pulse_start();
      repeat (10) @(negedge cap_clk);
      fork
         send_both(RUN, 4);
         begin
            wait (tx_cnt >= 20);
            pulse_start();
         end
      join
      wait_drain(2*RUN);
      check(tx_cnt == 2*RUN, "R5 R9 tx count", tx_cnt, 2*RUN);
      check(fb_cnt == 2*RUN, "R3 R5 fb count", fb_cnt, 2*RUN);
      check(done, "R5 done set", int'(done), 1);
      check(!ovf_err, "R7 no overflow in normal run", int'(ovf_err), 0);

      // R6 words after done are ignored
      send_both(4, 2);
      repeat (80) @(negedge cap_clk);
      check(tx_cnt == 2*RUN && fb_cnt == 2*RUN, "R6 ignored after done", tx_cnt + fb_cnt, 4*RUN);
      check(done, "R6 done held", int'(done), 1);

      // R6 re-arm, run 2
      tx_cnt = 0; fb_cnt = 0;
      pulse_start();
      #1;
      check(!done, "R6 start clears done", int'(done), 0);
      repeat (10) @(negedge cap_clk);
      send_both(RUN, 3);
      wait_drain(2*RUN);
      check(tx_cnt == 2*RUN, "R5 run2 tx count", tx_cnt, 2*RUN);
      check(fb_cnt == 2*RUN, "R3 run2 fb count", fb_cnt, 2*RUN);
      check(done, "R5 run2 done", int'(done), 1);

      // R7 overflow: lanes blocked, sources flood
      tx_ren = 0; fb_ren = 0;
      tx_cnt = 0; fb_cnt = 0;
      pulse_start();
      repeat (10) @(negedge cap_clk);
      send_both(30, 1);
      repeat (20) @(negedge cap_clk);
      check(ovf_err, "R7 overflow flagged", int'(ovf_err), 1);
      repeat (50) @(negedge cap_clk);
      check(ovf_err, "R7 overflow sticky", int'(ovf_err), 1);
      check(!done, "R7 run not complete", int'(done), 0);
      finish_run();
   end
endmodule